// File: doc/BRIEF.md
# Three-Range Pipelined Peak Digitizer

This block takes one shaped detector channel that has been digitized three times at once, by three 10-bit converters behind three different analog gains. All three streams run on a shared sample clock. Each stream passes through a fixed-length delay line. Because of that delay, the samples of a pulse are still present when the level-1 accept arrives a known number of clocks after the pulse. On an accept, the block scans a fixed run of delayed samples and keeps the largest value of each stream.

It then chooses one gain range: the most sensitive range that did not clip. It packs a two-bit range code with the ten-bit peak into a 12-bit word, giving about 15 bits of dynamic range. Words whose peak is below a programmable threshold are dropped. The remaining words go into a small first-in first-out event buffer, which reports when it is full. For calibration with a radioactive source, a discriminator on the delayed high-gain stream can start the same capture when the threshold is crossed, with no external accept needed. A clear input aborts a capture that is in progress. An accept that arrives during a capture is ignored and counted.

Top module: `gain_ranged_peak_capture`

## Requirements
- R1: The first sample in the window is the one sampled exactly LATENCY (default 64) clock edges before the edge that samples the accept. The sample one edge earlier is not part of the window.
- R2: The window spans WINDOW (default 50) consecutive delayed samples. A sample at offset WINDOW-1 affects the result, and a sample at offset WINDOW does not.
- R3: The range is chosen per capture from the maximum of each stream. High gain is used when its maximum is below 1023. Otherwise middle gain is used when its maximum is below 1023. Otherwise low gain is used, including when every range is at 1023.
- R4: The event word is 12 bits. Bits 11:10 hold the range code, 00 for high, 01 for middle and 10 for low. Bits 9:0 hold that range's peak value.
- R5: A word is stored only when its peak value is greater than or equal to the threshold input. An equal value is stored.
- R6: The buffer holds BUF_DEPTH (default 4) words. The full flag is high exactly when it holds that many, and a word produced while it is full is discarded.
- R7: When self-trigger mode is enabled, the first cycle in which the delayed high-gain sample rises above the threshold starts a capture, and that sample is the first sample of the window.
- R8: A pulse on the clear input during a capture ends the capture, and no word is stored for it.
- R9: An accept that arrives during a capture neither restarts nor extends it. Each such accept increments an 8-bit overlap count, which saturates at its maximum.
- R10: After reset the buffer is empty and not full, no capture is running, and the overlap count is zero.
- R11: Words leave the buffer in the order they were stored. The head word is shown whenever the valid flag is high, and a read strobe removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_hi_i | input | 10 | High-gain sample |
| adc_mid_i | input | 10 | Middle-gain sample |
| adc_lo_i | input | 10 | Low-gain sample |
| l1_trig_i | input | 1 | Level-1 accept, one clock wide |
| l1_clear_i | input | 1 | Abort the capture in progress |
| self_trig_en_i | input | 1 | Enable the threshold self-trigger |
| thresh_i | input | 10 | Threshold for discriminator and compression |
| rd_en_i | input | 1 | Remove the head word from the buffer |
| evt_valid_o | output | 1 | Buffer not empty, head word valid |
| evt_word_o | output | 12 | Head word: range code and peak |
| buf_full_o | output | 1 | Buffer full |
| busy_o | output | 1 | Capture window in progress |
| self_trig_o | output | 1 | Self-trigger fired this cycle |
| overlap_cnt_o | output | 8 | Number of accepts ignored during a capture |

## Verification
Some properties are checked by assertions on every cycle. A finished capture must always follow a busy cycle. A clear must leave the finder idle on the next cycle. The overlap count must step by one on each accept that arrives during a capture. The buffer count must not move when a write meets a full buffer, and must drop by one on a read. A middle-range word must only appear when the high-gain peak clipped. Other behaviour can only be shown by the bench's scenarios. These are the exact alignment of the window to the pipeline delay at both of its ends, the pick among the three ranges at the 1022/1023 boundary, the threshold edge, self-triggered captures, and the order of the buffered words when it fills.

// File: rtl/trd_pkg.sv
package trd_pkg;
   localparam int unsigned NUM_RANGES = 3;
   localparam int unsigned CODE_W     = 2;

   typedef enum logic [CODE_W-1:0] {
      RNG_HIGH = 2'b00,
      RNG_MID  = 2'b01,
      RNG_LOW  = 2'b10
   } range_e;

   // stream index inside the packed sample vector
   localparam int unsigned IDX_HIGH = 2;
   localparam int unsigned IDX_MID  = 1;
   localparam int unsigned IDX_LOW  = 0;
endpackage

// File: rtl/trd_delay_line.sv
module trd_delay_line #(
   parameter int unsigned W     = 30,
   parameter int unsigned DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= din;
         end
         assign dout = stage_q;
      end else begin : g_chain
         logic [W-1:0] stage_q [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= din;
               for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign dout = stage_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/trd_peak_finder.sv
module trd_peak_finder
   import trd_pkg::*;
#(
   parameter int unsigned W      = 10,
   parameter int unsigned WINDOW = 50,
   parameter int unsigned CNT_W  = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_RANGES-1:0][W-1:0]   samp,
   input  logic                           trig,
   input  logic                           clear,
   output logic                           busy,
   output logic                           done,
   output logic [NUM_RANGES-1:0][W-1:0]   peak,
   output logic [CNT_W-1:0]               overlap_cnt
);
   localparam int unsigned WIN_W   = $clog2(WINDOW + 1);
   localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(WINDOW - 1);

   logic [WIN_W-1:0]                 idx_q;
   logic [NUM_RANGES-1:0][W-1:0]     peak_nxt;

   genvar g;
   generate
      for (g = 0; g < NUM_RANGES; g++) begin : g_max
         assign peak_nxt[g] = (samp[g] > peak[g]) ? samp[g] : peak[g];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         done        <= 1'b0;
         idx_q       <= '0;
         peak        <= '0;
         overlap_cnt <= '0;
      end else begin
         done <= 1'b0;
         if (clear) begin
            busy  <= 1'b0;
            idx_q <= '0;
         end else if (!busy) begin
            if (trig) begin
               busy  <= 1'b1;
               idx_q <= WIN_W'(1);
               peak  <= samp;
            end
         end else begin
            peak <= peak_nxt;
            if (trig && (overlap_cnt != '1))
               overlap_cnt <= overlap_cnt + 1'b1;
            if (idx_q == LAST_IDX) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               idx_q <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));  // R2
   AST_CLEAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!busy && !done));  // R8
   AST_OVERLAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig && !clear && (overlap_cnt != '1)) |=>
         (overlap_cnt == CNT_W'($past(overlap_cnt) + 1'b1)));  // R9
endmodule

// File: rtl/trd_range_encoder.sv
module trd_range_encoder
   import trd_pkg::*;
#(
   parameter int unsigned W = 10
) (
   input  logic [NUM_RANGES-1:0][W-1:0] peak,
   input  logic [W-1:0]                 thresh,
   output range_e                       code,
   output logic [W-1:0]                 value,
   output logic                         keep
);
   localparam logic [W-1:0] SAT = '1;

   always_comb begin
      if (peak[IDX_HIGH] != SAT) begin
         code  = RNG_HIGH;
         value = peak[IDX_HIGH];
      end else if (peak[IDX_MID] != SAT) begin
         code  = RNG_MID;
         value = peak[IDX_MID];
      end else begin
         code  = RNG_LOW;
         value = peak[IDX_LOW];
      end
      keep = (value >= thresh);
   end
endmodule

// File: rtl/trd_event_fifo.sv
module trd_event_fifo #(
   parameter int unsigned DW    = 12,
   parameter int unsigned DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] din,
   input  logic          rd_en,
   output logic [DW-1:0] dout,
   output logic          not_empty,
   output logic          full
);
   localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW  = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CAP = CW'(DEPTH);

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q;
   logic          push, pop;

   assign full      = (count_q == CAP);
   assign not_empty = (count_q != '0);
   assign push      = wr_en && !full;
   assign pop       = rd_en && not_empty;
   assign dout      = mem_q[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_ptr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         if (pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> $stable(count_q));  // R6
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && not_empty && !wr_en) |=> (count_q == CW'($past(count_q) - 1'b1)));  // R11
endmodule

// File: rtl/gain_ranged_peak_capture.sv
module gain_ranged_peak_capture
   import trd_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 10,
   parameter int unsigned LATENCY   = 64,
   parameter int unsigned WINDOW    = 50,
   parameter int unsigned BUF_DEPTH = 4,
   parameter int unsigned OVL_W     = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SAMPLE_W-1:0]       adc_hi_i,
   input  logic [SAMPLE_W-1:0]       adc_mid_i,
   input  logic [SAMPLE_W-1:0]       adc_lo_i,
   input  logic                      l1_trig_i,
   input  logic                      l1_clear_i,
   input  logic                      self_trig_en_i,
   input  logic [SAMPLE_W-1:0]       thresh_i,
   input  logic                      rd_en_i,
   output logic                      evt_valid_o,
   output logic [CODE_W+SAMPLE_W-1:0] evt_word_o,
   output logic                      buf_full_o,
   output logic                      busy_o,
   output logic                      self_trig_o,
   output logic [OVL_W-1:0]          overlap_cnt_o
);
   localparam int unsigned BUS_W  = NUM_RANGES * SAMPLE_W;
   localparam int unsigned WORD_W = CODE_W + SAMPLE_W;

   generate
      if (WINDOW < 2) begin : g_bad_window
         $error("WINDOW must be at least 2");
      end
      if (LATENCY < 1) begin : g_bad_latency
         $error("LATENCY must be at least 1");
      end
      if ((BUF_DEPTH < 2) || ((BUF_DEPTH & (BUF_DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("BUF_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [NUM_RANGES-1:0][SAMPLE_W-1:0] raw_bus, dly_bus, peak;
   logic                                disc_now, disc_q, self_fire, trig;
   logic                                done;
   range_e                              code;
   logic [SAMPLE_W-1:0]                 value;
   logic                                keep;

   assign raw_bus[IDX_HIGH] = adc_hi_i;
   assign raw_bus[IDX_MID]  = adc_mid_i;
   assign raw_bus[IDX_LOW]  = adc_lo_i;

   trd_delay_line #(.W(BUS_W), .DEPTH(LATENCY)) delay_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_bus),
      .dout (dly_bus)
   );

   assign disc_now = (dly_bus[IDX_HIGH] > thresh_i);

   always_ff @(posedge clk) begin
      if (!rst_n) disc_q <= 1'b0;
      else        disc_q <= disc_now;
   end

   assign self_fire   = self_trig_en_i && disc_now && !disc_q;
   assign trig        = l1_trig_i || self_fire;
   assign self_trig_o = self_fire;

   trd_peak_finder #(.W(SAMPLE_W), .WINDOW(WINDOW), .CNT_W(OVL_W)) finder_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp       (dly_bus),
      .trig       (trig),
      .clear      (l1_clear_i),
      .busy       (busy_o),
      .done       (done),
      .peak       (peak),
      .overlap_cnt(overlap_cnt_o)
   );

   trd_range_encoder #(.W(SAMPLE_W)) encoder_i (
      .peak  (peak),
      .thresh(thresh_i),
      .code  (code),
      .value (value),
      .keep  (keep)
   );

   trd_event_fifo #(.DW(WORD_W), .DEPTH(BUF_DEPTH)) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (done && keep),
      .din      ({code, value}),
      .rd_en    (rd_en_i),
      .dout     (evt_word_o),
      .not_empty(evt_valid_o),
      .full     (buf_full_o)
   );

   AST_MID_NEEDS_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (code == RNG_MID)) |-> (peak[IDX_HIGH] == '1));  // R3
   AST_SELF_FIRE_IDLE_OR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (self_fire && !busy_o && !l1_clear_i) |=> busy_o);  // R7
endmodule

// File: tb/gain_ranged_peak_capture_tb_top.sv
module gain_ranged_peak_capture_tb_top;
   localparam int LAT   = 64;
   localparam int WIN   = 50;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] adc_hi = '0, adc_mid = '0, adc_lo = '0;
   logic       l1_trig = 1'b0, l1_clear = 1'b0, self_en = 1'b0, rd_en = 1'b0;
   logic [9:0] thresh = 10'd10;
   logic       evt_valid, buf_full, busy, self_trig;
   logic [11:0] evt_word;
   logic [7:0] overlap_cnt;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   gain_ranged_peak_capture dut_i (
      .clk(clk), .rst_n(rst_n),
      .adc_hi_i(adc_hi), .adc_mid_i(adc_mid), .adc_lo_i(adc_lo),
      .l1_trig_i(l1_trig), .l1_clear_i(l1_clear), .self_trig_en_i(self_en),
      .thresh_i(thresh), .rd_en_i(rd_en),
      .evt_valid_o(evt_valid), .evt_word_o(evt_word), .buf_full_o(buf_full),
      .busy_o(busy), .self_trig_o(self_trig), .overlap_cnt_o(overlap_cnt)
   );

   typedef struct packed {
      logic [9:0]        h;
      logic [9:0]        m;
      logic [9:0]        l;
      logic [9:0]        th;
      logic signed [7:0] off;
      logic              keep;
      logic [11:0]       word;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{10'd500,  10'd60,   10'd8,    10'd10, 8'sd0,  1'b1, {2'b00, 10'd500}},
      '{10'd1023, 10'd700,  10'd90,   10'd10, 8'sd10, 1'b1, {2'b01, 10'd700}},
      '{10'd1023, 10'd1023, 10'd400,  10'd10, 8'sd20, 1'b1, {2'b10, 10'd400}},
      '{10'd1023, 10'd1023, 10'd1023, 10'd10, 8'sd30, 1'b1, {2'b10, 10'd1023}},
      '{10'd1022, 10'd1023, 10'd1023, 10'd10, 8'sd5,  1'b1, {2'b00, 10'd1022}},
      '{10'd5,    10'd0,    10'd0,    10'd10, 8'sd3,  1'b0, 12'd0},
      '{10'd10,   10'd0,    10'd0,    10'd10, 8'sd49, 1'b1, {2'b00, 10'd10}},
      '{10'd900,  10'd0,    10'd0,    10'd10, 8'sd50, 1'b0, 12'd0},
      '{10'd900,  10'd0,    10'd0,    10'd10, -8'sd1, 1'b0, 12'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one-sample pulse; accept sampled LAT-off edges after the pulse edge
   task automatic fire(input logic [9:0] h, input logic [9:0] m, input logic [9:0] l, input int off);
      @(negedge clk);
      adc_hi = h; adc_mid = m; adc_lo = l;
      @(negedge clk);
      adc_hi = '0; adc_mid = '0; adc_lo = '0;
      repeat (LAT - off - 1) @(negedge clk);
      l1_trig = 1'b1;
      @(negedge clk);
      l1_trig = 1'b0;
   endtask

   task automatic settle();
      repeat (WIN + 3) @(negedge clk);
   endtask

   task automatic pop();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 valid after reset", evt_valid, 0);
      chk("R10 full after reset", buf_full, 0);
      chk("R10 busy after reset", busy, 0);
      chk("R10 overlap after reset", overlap_cnt, 0);

      // table walk: R1 R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         thresh = VECS[i].th;
         fire(VECS[i].h, VECS[i].m, VECS[i].l, int'(VECS[i].off));
         chk("R1 R2 busy during window", busy, 1);
         settle();
         chk("R5 R1 R2 stored flag", evt_valid, VECS[i].keep);
         if (VECS[i].keep) begin
            chk("R3 R4 word", evt_word, VECS[i].word);
            pop();
         end
         chk("R11 empty after pop", evt_valid, 0);
      end

      // overlap: R9
      fire(10'd200, 10'd20, 10'd2, 0);
      l1_trig = 1'b1;
      @(negedge clk);
      l1_trig = 1'b0;
      chk("R9 overlap count", overlap_cnt, 1);
      chk("R9 still busy", busy, 1);
      settle();
      chk("R9 one word", evt_valid, 1);
      chk("R9 word", evt_word, {2'b00, 10'd200});
      pop();
      chk("R9 no second word", evt_valid, 0);

      // clear: R8
      fire(10'd300, 10'd30, 10'd3, 0);
      repeat (5) @(negedge clk);
      l1_clear = 1'b1;
      @(negedge clk);
      l1_clear = 1'b0;
      chk("R8 idle after clear", busy, 0);
      settle();
      chk("R8 nothing stored", evt_valid, 0);

      // self trigger: R7
      thresh = 10'd100;
      self_en = 1'b1;
      @(negedge clk);
      adc_hi = 10'd300; adc_mid = 10'd40; adc_lo = 10'd5;
      @(negedge clk);
      adc_hi = 10'd0; adc_mid = 10'd0; adc_lo = 10'd0;
      repeat (LAT) @(negedge clk);
      chk("R7 self capture busy", busy, 1);
      settle();
      self_en = 1'b0;
      chk("R7 self word stored", evt_valid, 1);
      chk("R7 self word", evt_word, {2'b00, 10'd300});
      chk("R9 self capture no overlap", overlap_cnt, 1);
      pop();

      // fill buffer: R6 R11
      thresh = 10'd10;
      for (int k = 0; k < DEPTH + 1; k++) begin
         fire(10'(101 + k), 10'd0, 10'd0, 0);
         settle();
         if (k == DEPTH - 2) chk("R6 not full below depth", buf_full, 0);
      end
      chk("R6 full flag", buf_full, 1);
      for (int k = 0; k < DEPTH; k++) begin
         chk("R11 R6 order", evt_word, {2'b00, 10'(101 + k)});
         pop();
      end
      chk("R6 dropped word absent", evt_valid, 0);
      chk("R6 full cleared", buf_full, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule